// File: doc/BRIEF.md
# Backplane Frame Timing Unit

This block derives every timing reference that a 2.048 Mb/s time-division backplane needs from a 4.096 MHz serial clock and an 8 kHz frame pulse. It first works out which convention the frame pulse uses. An active-low pulse, with the line idle high, is the ST-BUS form. An active-high pulse, with the line idle low, is the GCI form. The decision is made over fixed windows of one frame length each, and it is accepted only when two windows in a row agree.

Once the format is known, the unit watches for the active edge of the frame pulse. It aligns a frame counter to that edge and declares lock. From the counter it produces the channel number, the bit number, a bit-boundary strobe, a sample-point strobe and strobes at the start and end of each channel, plus one at the start of each frame. It also reports which clock edge downstream shift logic should use for boundaries and for sampling, because the two conventions use opposite edges.

If the pulse stops arriving, the unit drops lock and begins detection again. Serial data storage and switching belong to neighbouring blocks.

Top module: `tdm_frame_timer`

## Requirements
- R1: While rst_n is low, locked, fmt_valid, all five strobes and the edge-select outputs are 0, and chan and bitn are 0.
- R2: With a frame-pulse line that idles high, fmt_valid is 0 after 1023 clocks following reset release. It becomes 1 with fmt_stbus = 1 after 1024 clocks, which is two agreeing windows of 512 clocks.
- R3: With a line that idles low, the detected format is fmt_stbus = 0 (GCI, active-high pulse).
- R4: After the format is accepted, locked rises 2 clocks after the first active pulse level is presented, meaning a change from the inactive to the active level. In the same cycle frame_start = 1, chan = 0 and bitn = 0.
- R5: Each bit cell lasts 2 clocks. bit_bnd is 1 in the first clock of the cell and smp_pt is 1 in the second, and the two are never 1 together.
- R6: bitn steps every 2 clocks through 0..7, and chan steps every 16 clocks through 0..31. chan_start is 1 in the clock with bitn 0 at the boundary phase. chan_end is a one-clock strobe in the clock with bitn 7 at the sample phase, and it is followed by chan_start.
- R7: Once the format is valid, bnd_on_fall = 1 and smp_on_fall = 0 for ST-BUS. For GCI, bnd_on_fall = 0 and smp_on_fall = 1.
- R8: An active pulse edge arriving at an unexpected position realigns the counter, so frame_start, chan = 0 and bitn = 0 appear 2 clocks after that pulse.
- R9: If no active pulse edge is seen for 1024 clocks after the last one, locked and fmt_valid both drop in the following clock and detection restarts.
- R10: While locked is 0, all five strobes stay 0.
- R11: The detected format does not change while locked stays 1.
- R12: If two consecutive windows disagree, fmt_valid stays 0. The format is then accepted at the end of the next window that agrees with its predecessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bus clock, two clocks per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 1 | Frame pulse of either polarity |
| fmt_valid | output | 1 | Format decision accepted |
| fmt_stbus | output | 1 | 1 = active-low pulse convention, 0 = active-high |
| locked | output | 1 | Counter aligned to the frame pulse |
| chan | output | 5 | Current channel number |
| bitn | output | 3 | Bit position within the channel |
| bit_bnd | output | 1 | Bit-boundary strobe |
| smp_pt | output | 1 | Sample-point strobe |
| chan_start | output | 1 | First clock of a channel |
| chan_end | output | 1 | Last clock of a channel |
| frame_start | output | 1 | First clock of a frame |
| bnd_on_fall | output | 1 | Bit boundaries belong on the falling clock edge |
| smp_on_fall | output | 1 | Sampling belongs on the falling clock edge |

## Verification
The properties assume that fp_in is synchronous to clk and that the active level of the pulse covers only a small part of a frame. They also assume that active edges are at least a channel apart, so realignment never lands on the cycle after a boundary strobe. The stimulus holds to this by driving fp_in only at the falling clock edge, with one-clock pulses every 512 clocks. The only exceptions are a single deliberate early pulse to test realignment and a constant-level stretch used to make two detection windows disagree.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
   typedef enum logic {
      FMT_GCI   = 1'b0,
      FMT_STBUS = 1'b1
   } fp_fmt_t;
endpackage

// File: rtl/tdm_pol_detect.sv
module tdm_pol_detect
   import tdm_sync_pkg::*;
#(
   parameter int FRAME_CLKS = 512
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fp_s,
   input  logic    restart,
   output logic    fmt_valid,
   output fp_fmt_t fmt
);
   localparam int WW = $clog2(FRAME_CLKS);
   localparam int HW = WW + 1;

   logic [WW-1:0] wcnt;
   logic [HW-1:0] hcnt;
   logic [HW-1:0] hsum;
   logic          have_prev;
   fp_fmt_t       prev_fmt;
   fp_fmt_t       win_fmt;

   always_comb begin
      hsum    = hcnt + HW'(fp_s);
      win_fmt = (hsum > HW'(FRAME_CLKS / 2)) ? FMT_STBUS : FMT_GCI;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         wcnt      <= '0;
         hcnt      <= '0;
         have_prev <= 1'b0;
         prev_fmt  <= FMT_GCI;
         fmt_valid <= 1'b0;
         fmt       <= FMT_GCI;
      end else if (!fmt_valid) begin
         if (wcnt == WW'(FRAME_CLKS - 1)) begin
            wcnt      <= '0;
            hcnt      <= '0;
            prev_fmt  <= win_fmt;
            have_prev <= 1'b1;
            if (have_prev && (prev_fmt == win_fmt)) begin
               fmt_valid <= 1'b1;
               fmt       <= win_fmt;
            end
         end else begin
            wcnt <= wcnt + 1'b1;
            hcnt <= hsum;
         end
      end
   end
endmodule

// File: rtl/tdm_pulse_track.sv
module tdm_pulse_track
   import tdm_sync_pkg::*;
#(
   parameter int FRAME_CLKS = 512
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fp_s,
   input  logic    fmt_valid,
   input  fp_fmt_t fmt,
   output logic    pulse_start,
   output logic    restart,
   output logic    locked
);
   localparam int TMO = 2 * FRAME_CLKS;
   localparam int TW  = $clog2(TMO);

   logic          fp_d;
   logic          act_lvl;
   logic [TW-1:0] sp_cnt;

   always_comb begin
      act_lvl     = (fmt == FMT_STBUS) ? 1'b0 : 1'b1;
      pulse_start = fmt_valid && (fp_s == act_lvl) && (fp_d != act_lvl);
      restart     = fmt_valid && !pulse_start && (sp_cnt == TW'(TMO - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fp_d   <= 1'b0;
         sp_cnt <= '0;
         locked <= 1'b0;
      end else begin
         fp_d <= fp_s;
         if (!fmt_valid || pulse_start || restart) sp_cnt <= '0;
         else                                      sp_cnt <= sp_cnt + 1'b1;
         if (!fmt_valid || restart) locked <= 1'b0;
         else if (pulse_start)      locked <= 1'b1;
      end
   end
endmodule

// File: rtl/tdm_timebase.sv
module tdm_timebase #(
   parameter int CHANNELS    = 32,
   parameter int BITS        = 8,
   parameter int CLK_PER_BIT = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        align,
   input  logic                        locked,
   output logic [$clog2(CHANNELS)-1:0] chan,
   output logic [$clog2(BITS)-1:0]     bitn,
   output logic                        bit_bnd,
   output logic                        smp_pt,
   output logic                        chan_start,
   output logic                        chan_end,
   output logic                        frame_start
);
   localparam int PW     = $clog2(CLK_PER_BIT);
   localparam int BW     = $clog2(BITS);
   localparam int CHW    = $clog2(CHANNELS);
   localparam int CW     = PW + BW + CHW;
   localparam int LAST   = CHANNELS * BITS * CLK_PER_BIT - 1;
   localparam int SMP_PH = (3 * CLK_PER_BIT) / 4;

   logic [CW-1:0] cnt;
   logic [PW-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (align)               cnt <= '0;
      else if (cnt == CW'(LAST))    cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end

   generate
      if (CLK_PER_BIT == 2) begin : g_phase_bit
         assign phase = cnt[0];
      end else begin : g_phase_slice
         assign phase = cnt[PW-1:0];
      end
   endgenerate

   always_comb begin
      bitn        = cnt[PW+BW-1:PW];
      chan        = cnt[CW-1:PW+BW];
      bit_bnd     = locked && (phase == '0);
      smp_pt      = locked && (phase == PW'(SMP_PH));
      chan_start  = bit_bnd && (bitn == '0);
      chan_end    = locked && (bitn == BW'(BITS - 1)) && (phase == PW'(CLK_PER_BIT - 1));
      frame_start = chan_start && (chan == '0);
   end
endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
   import tdm_sync_pkg::*;
#(
   parameter int CHANNELS    = 32,
   parameter int BITS        = 8,
   parameter int CLK_PER_BIT = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fp_in,
   output logic                        fmt_valid,
   output logic                        fmt_stbus,
   output logic                        locked,
   output logic [$clog2(CHANNELS)-1:0] chan,
   output logic [$clog2(BITS)-1:0]     bitn,
   output logic                        bit_bnd,
   output logic                        smp_pt,
   output logic                        chan_start,
   output logic                        chan_end,
   output logic                        frame_start,
   output logic                        bnd_on_fall,
   output logic                        smp_on_fall
);
   localparam int FRAME_CLKS = CHANNELS * BITS * CLK_PER_BIT;

   generate
      if (CLK_PER_BIT < 2 || (CLK_PER_BIT & (CLK_PER_BIT - 1)) != 0) begin : g_bad_cpb
         $error("CLK_PER_BIT must be a power of two of at least 2");
      end
      if (BITS < 2 || (BITS & (BITS - 1)) != 0) begin : g_bad_bits
         $error("BITS must be a power of two of at least 2");
      end
      if (CHANNELS < 2 || (CHANNELS & (CHANNELS - 1)) != 0) begin : g_bad_chan
         $error("CHANNELS must be a power of two of at least 2");
      end
   endgenerate

   logic    fp_s;
   logic    pulse_start;
   logic    restart;
   fp_fmt_t fmt;

   always_ff @(posedge clk) begin
      if (!rst_n) fp_s <= 1'b0;
      else        fp_s <= fp_in;
   end

   tdm_pol_detect #(.FRAME_CLKS(FRAME_CLKS)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .fp_s      (fp_s),
      .restart   (restart),
      .fmt_valid (fmt_valid),
      .fmt       (fmt)
   );

   tdm_pulse_track #(.FRAME_CLKS(FRAME_CLKS)) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .fp_s        (fp_s),
      .fmt_valid   (fmt_valid),
      .fmt         (fmt),
      .pulse_start (pulse_start),
      .restart     (restart),
      .locked      (locked)
   );

   tdm_timebase #(
      .CHANNELS    (CHANNELS),
      .BITS        (BITS),
      .CLK_PER_BIT (CLK_PER_BIT)
   ) u_tb (
      .clk         (clk),
      .rst_n       (rst_n),
      .align       (pulse_start),
      .locked      (locked),
      .chan        (chan),
      .bitn        (bitn),
      .bit_bnd     (bit_bnd),
      .smp_pt      (smp_pt),
      .chan_start  (chan_start),
      .chan_end    (chan_end),
      .frame_start (frame_start)
   );

   always_comb begin
      fmt_stbus   = (fmt == FMT_STBUS);
      bnd_on_fall = fmt_valid && (fmt == FMT_STBUS);
      smp_on_fall = fmt_valid && (fmt == FMT_GCI);
   end
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
   parameter int CHANNELS    = 32,
   parameter int BITS        = 8,
   parameter int CLK_PER_BIT = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fp_in,
   input logic                        fmt_valid,
   input logic                        fmt_stbus,
   input logic                        locked,
   input logic [$clog2(CHANNELS)-1:0] chan,
   input logic [$clog2(BITS)-1:0]     bitn,
   input logic                        bit_bnd,
   input logic                        smp_pt,
   input logic                        chan_start,
   input logic                        chan_end,
   input logic                        frame_start,
   input logic                        bnd_on_fall,
   input logic                        smp_on_fall
);
   logic unused_in;
   assign unused_in = fp_in ^ bnd_on_fall ^ smp_on_fall;

   p_lock_needs_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> fmt_valid);

   p_lock_on_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (frame_start && chan == '0 && bitn == '0));

   p_bnd_smp_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_bnd && smp_pt));

   p_end_then_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && chan_end) |=> (chan_start || !locked));

   p_quiet_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !(bit_bnd || smp_pt || chan_start || chan_end || frame_start));

   p_fmt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (!locked || $stable(fmt_stbus)));
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(
   .CHANNELS    (CHANNELS),
   .BITS        (BITS),
   .CLK_PER_BIT (CLK_PER_BIT)
) u_chk (.*);

// File: tb/tdm_frame_timer_test.sv
module tdm_frame_timer_test;
   logic       clk;
   logic       rst_n;
   logic       fp_in;
   logic       fmt_valid, fmt_stbus, locked;
   logic [4:0] chan;
   logic [2:0] bitn;
   logic       bit_bnd, smp_pt, chan_start, chan_end, frame_start;
   logic       bnd_on_fall, smp_on_fall;

   int n_checks = 0;
   int n_errors = 0;
   int bcnt     = 0;
   int off      = 100;
   bit fp_run   = 0;
   bit act      = 0;
   bit hold_hi  = 0;
   bit done     = 0;

   typedef struct packed {
      int   k;
      int   ch;
      int   bt;
      logic bnd;
      logic smp;
      logic cs;
      logic ce;
      logic fs;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TAB [NV] = '{
      '{0,   0,  0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      '{1,   0,  0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{2,   0,  1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{14,  0,  7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{15,  0,  7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{16,  1,  0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{17,  1,  0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      '{100, 6,  2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      '{255, 15, 7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{256, 16, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{511, 31, 7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
   };

   tdm_frame_timer uut (
      .clk(clk), .rst_n(rst_n), .fp_in(fp_in),
      .fmt_valid(fmt_valid), .fmt_stbus(fmt_stbus), .locked(locked),
      .chan(chan), .bitn(bitn), .bit_bnd(bit_bnd), .smp_pt(smp_pt),
      .chan_start(chan_start), .chan_end(chan_end), .frame_start(frame_start),
      .bnd_on_fall(bnd_on_fall), .smp_on_fall(smp_on_fall)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d (bcnt %0d)", req, actual, expected, bcnt);
      end
   endtask

   task automatic drive_fp();
      if (hold_hi && bcnt < 512)                  fp_in = 1'b1;
      else if (fp_run && (bcnt % 512) == off)     fp_in = act;
      else                                        fp_in = ~act;
   endtask

   task automatic step();
      @(negedge clk);
      bcnt++;
      drive_fp();
   endtask

   task automatic run_to(input int b);
      while (bcnt < b) step();
   endtask

   function automatic int rel();
      int x;
      x = bcnt - off - 2;
      return ((x % 512) + 512) % 512;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      bcnt  = 0;
      drive_fp();
      repeat (4) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      bcnt  = 0;
      drive_fp();
   endtask

   task automatic strobes_zero(input string req);
      check(req, int'({bit_bnd, smp_pt, chan_start, chan_end, frame_start}), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      fp_in = 1'b1;
      // ST-BUS run: idle high, active-low pulses
      act = 1'b0; fp_run = 1'b1; off = 100; hold_hi = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 locked", int'(locked), 0);
      check("R1 fmt_valid", int'(fmt_valid), 0);
      strobes_zero("R1 strobes");
      check("R1 chan", int'(chan), 0);
      check("R1 bitn", int'(bitn), 0);
      check("R1 edge select", int'({bnd_on_fall, smp_on_fall}), 0);
      do_reset();

      run_to(1023);
      check("R2 fmt_valid early", int'(fmt_valid), 0);
      run_to(1024);
      check("R2 fmt_valid", int'(fmt_valid), 1);
      check("R2 fmt_stbus", int'(fmt_stbus), 1);
      run_to(1125);
      check("R4 locked before pulse", int'(locked), 0);
      strobes_zero("R10 strobes unlocked");
      run_to(1126);
      check("R4 locked", int'(locked), 1);
      check("R4 frame_start", int'(frame_start), 1);
      check("R7 bnd_on_fall stbus", int'(bnd_on_fall), 1);
      check("R7 smp_on_fall stbus", int'(smp_on_fall), 0);

      // R5 and R6: walk the position table over one frame
      for (int i = 0; i < NV; i++) begin
         while (rel() != TAB[i].k) step();
         check("R6 chan", int'(chan), TAB[i].ch);
         check("R6 bitn", int'(bitn), TAB[i].bt);
         check("R5 bit_bnd", int'(bit_bnd), int'(TAB[i].bnd));
         check("R5 smp_pt", int'(smp_pt), int'(TAB[i].smp));
         check("R6 chan_start", int'(chan_start), int'(TAB[i].cs));
         check("R6 chan_end", int'(chan_end), int'(TAB[i].ce));
         check("R6 frame_start", int'(frame_start), int'(TAB[i].fs));
      end

      // R8: early pulse realigns the counter
      step();
      while (rel() != 0) step();
      off = (bcnt + 50) % 512;
      run_to(bcnt + 51);
      check("R8 no frame_start before realign", int'(frame_start), 0);
      check("R8 chan before realign", int'(chan), 3);
      step();
      check("R8 frame_start", int'(frame_start), 1);
      check("R8 chan", int'(chan), 0);
      check("R8 bitn", int'(bitn), 0);
      check("R11 fmt held", int'(fmt_stbus), 1);

      // R9: pulses stop; last active pulse was driven at bcnt-2
      begin
         int p;
         p = bcnt - 2;
         fp_run = 1'b0;
         run_to(p + 1025);
         check("R9 still locked", int'(locked), 1);
         run_to(p + 1026);
         check("R9 locked dropped", int'(locked), 0);
         check("R9 fmt_valid dropped", int'(fmt_valid), 0);
         run_to(p + 1031);
         strobes_zero("R10 strobes after timeout a");
         step();
         strobes_zero("R10 strobes after timeout b");
      end

      // R12 then R3: first window high, then GCI idle-low line
      act = 1'b1; fp_run = 1'b1; off = 100; hold_hi = 1;
      do_reset();
      run_to(1024);
      check("R12 disagreeing windows", int'(fmt_valid), 0);
      run_to(1536);
      check("R12 accepted after agreement", int'(fmt_valid), 1);
      check("R3 fmt_stbus gci", int'(fmt_stbus), 0);
      run_to(1637);
      check("R4 gci not locked", int'(locked), 0);
      run_to(1638);
      check("R4 gci locked", int'(locked), 1);
      check("R4 gci frame_start", int'(frame_start), 1);
      check("R7 bnd_on_fall gci", int'(bnd_on_fall), 0);
      check("R7 smp_on_fall gci", int'(smp_on_fall), 1);
      run_to(1638 + 15);
      check("R6 gci chan_end", int'(chan_end), 1);
      check("R6 gci bitn", int'(bitn), 7);
      step();
      check("R6 gci chan_start", int'(chan_start), 1);
      check("R6 gci chan", int'(chan), 1);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(100000 * 20);
      if (!done) begin
         done = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got 1 expected 0 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule